// File: doc/BRIEF.md
# Change-of-Flow Trace Recorder

This block watches a processor's retire stream and keeps a history of the program's flow changes in a small circular memory. A debugger reads that history back afterwards. Each retired instruction arrives with a two-bit kind code and both its source and destination addresses. A separate strobe reports an interrupt vector fetch and its vector address. Only indirect jumps, returns, taken conditional branches and non-debug interrupt vectors produce entries. Each entry holds an 18-bit address and one flag that tells a source address from a destination address.

Recording runs while `arm_i` is high. A rising edge of `arm_i` starts a fresh history. Dropping `arm_i` freezes the memory, so its contents can be read at leisure through an index port. Index 0 of that port is always the oldest valid entry. An optional loop-filter mode stops a tight polling or countdown loop from filling the memory with copies of the same branch source.

Top module: `cof_trace_rec`

## Requirements
- R1: After reset, `wr_ptr_o`, `count_o`, `wrap_o`, `rd_vld_o`, `rd_src_o` and `rd_addr_o` are all zero.
- R2: A retire with kind 2'b01 (indexed jump or call) or kind 2'b10 (return of any sort) writes one entry that holds `dst_addr_i` with the source flag at 0.
- R3: A retire with kind 2'b11 (taken conditional or loop-decrement branch) writes one entry that holds `src_addr_i` with the source flag at 1.
- R4: A retire with kind 2'b00 (no recorded flow change) writes nothing, and the pointer and count stay unchanged. This kind covers plain instructions, direct branches, branch-to-subroutine, the background instruction and direct jumps and calls.
- R5: `vec_i` with `vec_dbg_i` low writes `vec_addr_i` as an entry with the source flag at 0. `vec_i` with `vec_dbg_i` high writes nothing.
- R6: When an instruction entry and a vector entry occur in the same cycle, the instruction entry goes to the lower slot and the vector entry to the next slot. The pointer then advances by two.
- R7: With `loop_mode_i` high, a kind 2'b11 entry is dropped when the most recently stored entry is a source entry with the same address. Destination and vector entries are always stored. With `loop_mode_i` low, duplicate entries are stored.
- R8: The memory holds 64 entries and the pointer wraps modulo 64. `wrap_o` is set by the first rollover and stays set. `count_o` saturates at 64.
- R9: While `arm_i` is low, nothing is written. In the cycle where `arm_i` rises, the pointer, count, wrap flag and filter history are cleared before that cycle's entries are written.
- R10: `rd_idx_i` selects an entry counted from the oldest one. The oldest entry is in slot 0 when the memory has not wrapped, and in slot `wr_ptr_o` when it has. The entry appears on `rd_src_o`/`rd_addr_o` one cycle later. `rd_vld_o` is high when the index is below `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Recording enable; a rising edge restarts the history |
| loop_mode_i | input | 1 | Drop repeated branch-source entries |
| retire_i | input | 1 | An instruction retires this cycle |
| kind_i | input | 2 | Flow-change kind of the retiring instruction |
| src_addr_i | input | 18 | Address of the retiring instruction |
| dst_addr_i | input | 18 | Address where the retiring instruction goes |
| vec_i | input | 1 | An interrupt vector is fetched this cycle |
| vec_dbg_i | input | 1 | The fetched vector belongs to the debug mode |
| vec_addr_i | input | 18 | Fetched vector address |
| rd_idx_i | input | 6 | Read index counted from the oldest entry |
| wr_ptr_o | output | 6 | Next slot to be written |
| count_o | output | 7 | Number of valid entries, 0 to 64 |
| wrap_o | output | 1 | Pointer has rolled over since arming |
| rd_vld_o | output | 1 | Read index was below the count |
| rd_src_o | output | 1 | Source flag of the entry that was read |
| rd_addr_o | output | 18 | Address of the entry that was read |

## Verification
The assertions check the following on every clock:
- the relation between count, pointer and wrap flag;
- the stickiness of the wrap flag;
- the frozen state while disarmed;
- the two-slot advance for coincident events;
- the silence of debug vectors;
- the absence of a stored duplicate branch source in loop mode.

The stored contents, their order within a cycle and the source flags are visible only through read-back after a scenario. The same holds for the oldest-first read index after a wrap and for the clearing on re-arm. The bench compares these against its own model of the memory.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    localparam int unsigned TR_ADDR_W = 18;

    typedef enum logic [1:0] {
        COF_NONE    = 2'b00,
        COF_INDIR   = 2'b01,
        COF_RETURN  = 2'b10,
        COF_BRTAKEN = 2'b11
    } cof_kind_e;

    typedef struct packed {
        logic                 is_src;
        logic [TR_ADDR_W-1:0] addr;
    } trace_ent_t;

endpackage

// File: rtl/cof_classify.sv
module cof_classify
    import cof_trace_pkg::*;
(
    input  logic                 retire_i,
    input  cof_kind_e            kind_i,
    input  logic [TR_ADDR_W-1:0] src_addr_i,
    input  logic [TR_ADDR_W-1:0] dst_addr_i,
    input  logic                 vec_i,
    input  logic                 vec_dbg_i,
    input  logic [TR_ADDR_W-1:0] vec_addr_i,
    input  logic                 loop_mode_i,
    input  logic                 last_vld_i,
    input  trace_ent_t           last_i,
    output logic [1:0]           n_wr_o,
    output trace_ent_t           ent0_o,
    output trace_ent_t           ent1_o,
    output trace_ent_t           last_o
);

    logic       ins_vld;
    logic       vec_vld;
    logic       dup;
    trace_ent_t ins_ent;
    trace_ent_t vec_ent;

    always_comb begin
        ins_vld = 1'b0;
        ins_ent = '0;
        dup     = 1'b0;
        if (retire_i) begin
            unique case (kind_i)
                COF_INDIR, COF_RETURN: begin
                    ins_vld = 1'b1;
                    ins_ent = '{is_src: 1'b0, addr: dst_addr_i};
                end
                COF_BRTAKEN: begin
                    dup     = loop_mode_i && last_vld_i && last_i.is_src
                              && (last_i.addr == src_addr_i);
                    ins_vld = !dup;
                    ins_ent = '{is_src: 1'b1, addr: src_addr_i};
                end
                default: ins_vld = 1'b0;
            endcase
        end
        vec_vld = vec_i && !vec_dbg_i;
        vec_ent = '{is_src: 1'b0, addr: vec_addr_i};

        ent0_o = ins_vld ? ins_ent : vec_ent;
        ent1_o = vec_ent;
        n_wr_o = {1'b0, ins_vld} + {1'b0, vec_vld};
        last_o = vec_vld ? vec_ent : ins_ent;
    end

    // R7: in loop mode a stored branch source never repeats the last source entry
    always_comb begin
        if (loop_mode_i && last_vld_i && last_i.is_src && n_wr_o != 2'd0
            && ent0_o.is_src) begin
            a_r7_no_repeat: assert (ent0_o.addr != last_i.addr);
        end
    end

endmodule

// File: rtl/cof_trace_mem.sv
module cof_trace_mem
    import cof_trace_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we0_i,
    input  logic [PTR_W-1:0] wa0_i,
    input  trace_ent_t       wd0_i,
    input  logic             we1_i,
    input  logic [PTR_W-1:0] wa1_i,
    input  trace_ent_t       wd1_i,
    input  logic [PTR_W-1:0] ra_i,
    output trace_ent_t       rd_o
);

    trace_ent_t mem_q [DEPTH];
    trace_ent_t mem_d [DEPTH];
    trace_ent_t rd_d;
    trace_ent_t rd_q;

    always_comb begin
        mem_d = mem_q;
        if (we0_i) mem_d[wa0_i] = wd0_i;
        if (we1_i) mem_d[wa1_i] = wd1_i;
        rd_d = mem_q[ra_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_o = rd_q;

    // R6: the two write ports never target the same slot in one cycle
    always_ff @(posedge clk_i) begin
        if (rst_ni && we0_i && we1_i) begin
            a_r6_distinct_slots: assert (wa0_i != wa1_i);
        end
    end

endmodule

// File: rtl/cof_trace_rec.sv
module cof_trace_rec
    import cof_trace_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 arm_i,
    input  logic                 loop_mode_i,
    input  logic                 retire_i,
    input  logic [1:0]           kind_i,
    input  logic [TR_ADDR_W-1:0] src_addr_i,
    input  logic [TR_ADDR_W-1:0] dst_addr_i,
    input  logic                 vec_i,
    input  logic                 vec_dbg_i,
    input  logic [TR_ADDR_W-1:0] vec_addr_i,
    input  logic [PTR_W-1:0]     rd_idx_i,
    output logic [PTR_W-1:0]     wr_ptr_o,
    output logic [CNT_W-1:0]     count_o,
    output logic                 wrap_o,
    output logic                 rd_vld_o,
    output logic                 rd_src_o,
    output logic [TR_ADDR_W-1:0] rd_addr_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
        logic             wrap;
        logic             arm;
        logic             last_vld;
        trace_ent_t       last;
        logic             rd_vld;
    } rec_state_t;

    rec_state_t st_q, st_d;

    logic             rise;
    logic [PTR_W-1:0] base_ptr;
    logic [CNT_W-1:0] base_cnt;
    logic             base_wrap;
    logic             base_lv;
    logic [1:0]       n_wr;
    logic [1:0]       n_eff;
    logic [CNT_W-1:0] ptr_sum;
    logic [CNT_W-1:0] cnt_sum;
    logic [PTR_W-1:0] oldest;
    logic [PTR_W-1:0] rd_slot;
    trace_ent_t       ent0, ent1, new_last, rd_ent;

    assign rise      = arm_i && !st_q.arm;
    assign base_ptr  = rise ? '0 : st_q.ptr;
    assign base_cnt  = rise ? '0 : st_q.cnt;
    assign base_wrap = rise ? 1'b0 : st_q.wrap;
    assign base_lv   = rise ? 1'b0 : st_q.last_vld;

    cof_classify u_cls (
        .retire_i    (retire_i),
        .kind_i      (cof_kind_e'(kind_i)),
        .src_addr_i  (src_addr_i),
        .dst_addr_i  (dst_addr_i),
        .vec_i       (vec_i),
        .vec_dbg_i   (vec_dbg_i),
        .vec_addr_i  (vec_addr_i),
        .loop_mode_i (loop_mode_i),
        .last_vld_i  (base_lv),
        .last_i      (st_q.last),
        .n_wr_o      (n_wr),
        .ent0_o      (ent0),
        .ent1_o      (ent1),
        .last_o      (new_last)
    );

    always_comb begin
        st_d     = st_q;
        n_eff    = arm_i ? n_wr : 2'd0;
        ptr_sum  = CNT_W'(base_ptr) + CNT_W'(n_eff);
        cnt_sum  = base_cnt + CNT_W'(n_eff);

        st_d.arm      = arm_i;
        st_d.ptr      = ptr_sum[PTR_W-1:0];
        st_d.wrap     = base_wrap | ptr_sum[PTR_W];
        st_d.cnt      = (cnt_sum > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cnt_sum;
        st_d.last_vld = base_lv;
        if (n_eff != 2'd0) begin
            st_d.last_vld = 1'b1;
            st_d.last     = new_last;
        end

        oldest      = st_q.wrap ? st_q.ptr : '0;
        rd_slot     = oldest + rd_idx_i;
        st_d.rd_vld = {1'b0, rd_idx_i} < st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    cof_trace_mem #(.DEPTH(DEPTH)) u_mem (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we0_i  (n_eff != 2'd0),
        .wa0_i  (base_ptr),
        .wd0_i  (ent0),
        .we1_i  (n_eff == 2'd2),
        .wa1_i  (base_ptr + PTR_W'(1)),
        .wd1_i  (ent1),
        .ra_i   (rd_slot),
        .rd_o   (rd_ent)
    );

    assign wr_ptr_o  = st_q.ptr;
    assign count_o   = st_q.cnt;
    assign wrap_o    = st_q.wrap;
    assign rd_vld_o  = st_q.rd_vld;
    assign rd_src_o  = rd_ent.is_src;
    assign rd_addr_o = rd_ent.addr;

    // R8: count never exceeds the memory depth
    a_r8_cnt_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_W'(DEPTH));
    // R8: a wrapped memory is full, an unwrapped one counts up to the pointer
    a_r8_wrap_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> count_o == CNT_W'(DEPTH));
    a_r8_unwrapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_o |-> count_o == CNT_W'(wr_ptr_o));
    // R8: the wrap flag holds until a re-arm
    a_r8_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_o && !rise) |=> wrap_o);
    // R9: disarmed recorder keeps its state
    a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> ($stable(wr_ptr_o) && $stable(count_o) && $stable(wrap_o)));
    // R5: a debug-mode vector alone writes nothing
    a_r5_dbg_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && st_q.arm && vec_i && vec_dbg_i && !retire_i)
        |=> ($stable(wr_ptr_o) && $stable(count_o)));
    // R6: coincident entries advance the pointer by two
    a_r6_two_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && st_q.arm && n_wr == 2'd2)
        |=> wr_ptr_o == PTR_W'($past(wr_ptr_o) + PTR_W'(2)));

endmodule

// File: tb/sim_cof_trace_rec.sv
`timescale 1ns/1ps
module sim_cof_trace_rec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 0, loop = 0, retire = 0, vec = 0, vdbg = 0;
    logic [1:0]  kind = 0;
    logic [17:0] src = 0, dst = 0, vaddr = 0;
    logic [5:0]  rd_idx = 0;
    logic [5:0]  wr_ptr;
    logic [6:0]  count;
    logic        wrap, rd_vld, rd_src;
    logic [17:0] rd_addr;

    int checks = 0, errors = 0;

    logic [18:0] m_mem [64];
    int          m_ptr = 0, m_cnt = 0;
    logic        m_wrap = 0, m_lv = 0, m_armq = 0;
    logic [18:0] m_last = 0;

    always #4 clk = ~clk;

    cof_trace_rec u0 (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .loop_mode_i(loop),
        .retire_i(retire), .kind_i(kind), .src_addr_i(src), .dst_addr_i(dst),
        .vec_i(vec), .vec_dbg_i(vdbg), .vec_addr_i(vaddr), .rd_idx_i(rd_idx),
        .wr_ptr_o(wr_ptr), .count_o(count), .wrap_o(wrap), .rd_vld_o(rd_vld),
        .rd_src_o(rd_src), .rd_addr_o(rd_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int oldest_slot();
        return m_wrap ? m_ptr : 0;
    endfunction

    task automatic push(input logic [18:0] e);
        m_mem[m_ptr] = e;
        m_ptr = (m_ptr + 1) % 64;
        if (m_ptr == 0) m_wrap = 1;
        if (m_cnt < 64) m_cnt++;
        m_last = e;
        m_lv = 1;
    endtask

    task automatic model_step();
        if (arm && !m_armq) begin
            m_ptr = 0; m_cnt = 0; m_wrap = 0; m_lv = 0;
        end
        if (arm) begin
            if (retire) begin
                case (kind)
                    2'b01, 2'b10: push({1'b0, dst});
                    2'b11: if (!(loop && m_lv && m_last[18] && m_last[17:0] == src))
                               push({1'b1, src});
                    default: ;
                endcase
            end
            if (vec && !vdbg) push({1'b0, vaddr});
        end
        m_armq = arm;
    endtask

    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " ptr"},   32'(wr_ptr), 32'(m_ptr));
        chk({tag, " count"}, 32'(count),  32'(m_cnt));
        chk({tag, " wrap"},  32'(wrap),   32'(m_wrap));
    endtask

    task automatic idle();
        retire = 0; vec = 0; vdbg = 0; kind = 0;
    endtask

    task automatic ev(input logic [1:0] k, input logic [17:0] s, input logic [17:0] d,
                      input logic v, input logic vd, input logic [17:0] va, input string tag);
        retire = (k != 0) || !v; kind = k; src = s; dst = d;
        vec = v; vdbg = vd; vaddr = va;
        step(tag);
        idle();
    endtask

    task automatic read_all(input string tag);
        arm = 0; idle();
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i);
            step({tag, " R9 frozen"});
            chk({tag, " R10 valid"}, 32'(rd_vld), 32'(i < m_cnt));
            if (i < m_cnt) begin
                chk({tag, " R10 addr"}, 32'(rd_addr), 32'(m_mem[(oldest_slot() + i) % 64][17:0]));
                chk({tag, " R10 flag"}, 32'(rd_src),  32'(m_mem[(oldest_slot() + i) % 64][18]));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 ptr", 32'(wr_ptr), 0);
        chk("R1 count", 32'(count), 0);
        chk("R1 wrap", 32'(wrap), 0);
        chk("R1 rd", 32'({rd_vld, rd_src, rd_addr}), 0);
        rst_n = 1;

        arm = 1; loop = 0;
        ev(2'b01, 18'h00100, 18'h20000, 0, 0, 0, "R2 indirect");
        ev(2'b10, 18'h00104, 18'h00050, 0, 0, 0, "R2 return");
        ev(2'b00, 18'h00108, 18'h3FFFF, 0, 0, 0, "R4 none");
        ev(2'b11, 18'h0010C, 18'h00100, 0, 0, 0, "R3 taken");
        ev(2'b00, 0, 0, 1, 1, 18'h3FFF0, "R5 debug vector");
        ev(2'b00, 0, 0, 1, 0, 18'h3FFF2, "R5 vector");
        ev(2'b01, 18'h00200, 18'h01234, 1, 0, 18'h3FFF4, "R6 coincident");
        ev(2'b11, 18'h00300, 0, 0, 0, 0, "R7 plain first");
        ev(2'b11, 18'h00300, 0, 0, 0, 0, "R7 plain duplicate");
        loop = 1;
        ev(2'b11, 18'h00300, 0, 0, 0, 0, "R7 loop duplicate");
        ev(2'b11, 18'h00300, 0, 0, 0, 0, "R7 loop duplicate again");
        ev(2'b10, 18'h00300, 18'h00400, 0, 0, 0, "R7 destination kept");
        ev(2'b10, 18'h00300, 18'h00400, 0, 0, 0, "R7 destination repeat kept");
        ev(2'b11, 18'h00300, 0, 0, 0, 0, "R7 source after destination");
        read_all("directed");

        arm = 1;
        for (int n = 0; n < 400; n++) begin
            loop   = (n >= 200);
            retire = 1'($urandom % 4 != 0);
            kind   = 2'($urandom);
            src    = 18'h00500 + 18'($urandom % 3);
            dst    = 18'($urandom);
            vec    = 1'($urandom % 6 == 0);
            vdbg   = 1'($urandom % 3 == 0);
            vaddr  = 18'h3FF00 + 18'($urandom % 16);
            step("R8 random");
        end
        idle();
        chk("R8 wrapped", 32'(wrap), 1);
        chk("R8 saturated", 32'(count), 64);
        arm = 0;
        for (int n = 0; n < 20; n++) begin
            retire = 1; kind = 2'b01; dst = 18'($urandom);
            vec = 1; vdbg = 0; vaddr = 18'($urandom);
            step("R9 disarmed");
        end
        read_all("random");

        arm = 1; idle();
        step("R9 rearm clear");
        chk("R9 cleared count", 32'(count), 0);
        ev(2'b11, 18'h00777, 0, 0, 0, 0, "R9 fresh entry");
        read_all("rearm");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule